// File: doc/BRIEF.md
# Decimation chain timing controller

This block produces every timing strobe for a three-stage decimating filter chain that sits behind an oversampling modulator. All of it is derived from a single master clock. A divide-by-two enable paces the modulator samples into the chain. The first stage divides by a fixed four. The middle stage divides by 8, 16 or 32, chosen by a two-bit rate select. The last stage divides by a fixed two, so the chain decimates by 64, 128 or 256 overall. The output-ready strobe therefore fires once every 128, 256 or 512 master-clock periods.

A settle timer runs alongside the strobes. It raises a settled flag a fixed, rate-dependent number of master-clock periods after the chain restarts. That count is long enough to cover roughly twice the filter delay plus the computation time, so the flag marks the first output that can be trusted. A synchronisation pulse restarts the chain and so does any effective change of the rate select. A restart realigns all stage phases on the next clock and clears the flag. Output-ready strobes are withheld until the flag is set.

All strobes are one master-clock cycle wide and are meant as clock enables. No derived clock exists.

Top module: `decim_timing_ctrl`

## Requirements
- R1: Count master-clock edges from a restart edge, where that edge is n = 0. The modulator enable `mod_ce_o` is high exactly in the cycles where n is odd, which is half the master rate.
- R2: The first-stage enable `s1_ce_o` is high exactly when n mod 8 = 7, which is once per four modulator samples.
- R3: The second-stage enable `s2_ce_o` is high exactly when n mod (8·D) = 8·D−1. D is 8, 16 or 32 for an overall decimation of 64, 128 or 256.
- R4: The unsuppressed output strobe falls where n mod (16·D) = 16·D−1. Its rate is the modulator rate divided by the overall decimation.
- R5: `settled_o` is low for n < L and high from n = L onward, where L is the settle length of the active rate. L is set by parameters that default to 7122, 14217 and 27895 for decimation 64, 128 and 256.
- R6: If `sync_i` is high at a clock edge, that edge becomes a restart edge: all phases go to n = 0 and `settled_o` clears.
- R7: An effective change of the decoded rate at a clock edge is a restart edge. From then on, the new rate's stage ratio and settle length L apply.
- R8: `odr_o` is low while `settled_o` is low. Once `settled_o` is high, `odr_o` fires at every position given in R4.
- R9: Rate select encoding is 00 for 64, 01 for 128, 10 for 256, and 11 also for 256. Switching between 10 and 11 is not a change and does not disturb the phases or the flag.
- R10: After a reset edge, which counts as a restart edge using the current rate select, all strobes and `settled_o` are low.
- R11: Every strobe is high for a single master-clock cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Synchronisation request, sampled each edge |
| rate_sel_i | input | 2 | Overall decimation select |
| mod_ce_o | output | 1 | Modulator sample enable |
| s1_ce_o | output | 1 | First-stage output enable |
| s2_ce_o | output | 1 | Second-stage output enable |
| odr_o | output | 1 | Output-data-ready strobe |
| settled_o | output | 1 | Filter-settled flag |

## Verification
The bench overrides the three settle lengths with 300, 520 and 900 master clocks instead of the multi-thousand defaults. With these values, settling at all three rates, repeated restarts and rate switches fit into a few thousand cycles. Each length lands partway through an output period, so at every rate the bench sees one or more output strobes that are suppressed before the flag rises and the first strobe that is allowed through after it.

// File: rtl/decim_timing_pkg.sv
package decim_timing_pkg;

    localparam int NUM_STAGES = 4;
    localparam int MOD_DIV    = 2;
    localparam int S1_RATIO   = 4;
    localparam int S3_RATIO   = 2;
    localparam int S2_MIN     = 8;
    localparam int S2_MAX     = 32;
    localparam int CNT_W      = $clog2(S2_MAX + 1);

    typedef enum logic [1:0] {
        RATE_64  = 2'd0,
        RATE_128 = 2'd1,
        RATE_256 = 2'd2
    } rate_e;

    typedef struct packed {
        logic mod_ce;
        logic s1_ce;
        logic s2_ce;
        logic s3_ce;
    } strobe_t;

    function automatic rate_e decode_rate(input logic [1:0] sel);
        case (sel)
            2'b00:   return RATE_64;
            2'b01:   return RATE_128;
            default: return RATE_256;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] mid_ratio(input rate_e r);
        case (r)
            RATE_64:  return CNT_W'(S2_MIN);
            RATE_128: return CNT_W'(S2_MIN * 2);
            default:  return CNT_W'(S2_MIN * 4);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] stage_ratio(input int idx, input rate_e r);
        case (idx)
            0:       return CNT_W'(MOD_DIV);
            1:       return CNT_W'(S1_RATIO);
            2:       return mid_ratio(r);
            default: return CNT_W'(S3_RATIO);
        endcase
    endfunction

endpackage

// File: rtl/decim_stage_ctr.sv
module decim_stage_ctr
    import decim_timing_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         ce_in_i,
    input  logic [W-1:0] ratio_i,
    output logic         ce_out_o
);

    logic [W-1:0] phase_q;
    logic         at_last;

    assign at_last  = (phase_q == ratio_i - W'(1));
    assign ce_out_o = ce_in_i & at_last;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            phase_q <= '0;
        end else if (ce_in_i) begin
            phase_q <= at_last ? '0 : phase_q + W'(1);
        end
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        phase_q < ratio_i); // R3

    AST_STAGE_PULSE: assert property (@(posedge clk) disable iff (rst)
        ce_out_o |=> !ce_out_o); // R11

endmodule

// File: rtl/decim_strobe_chain.sv
module decim_strobe_chain
    import decim_timing_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clear_i,
    input  rate_e   rate_i,
    output strobe_t strobes_o
);

    logic [NUM_STAGES:0] ce_link;

    assign ce_link[0] = 1'b1;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        logic [CNT_W-1:0] ratio;
        assign ratio = stage_ratio(g, rate_i);

        decim_stage_ctr #(.W(CNT_W)) u_ctr (
            .clk      (clk),
            .rst      (rst),
            .clear_i  (clear_i),
            .ce_in_i  (ce_link[g]),
            .ratio_i  (ratio),
            .ce_out_o (ce_link[g+1])
        );
    end

    assign strobes_o.mod_ce = ce_link[1];
    assign strobes_o.s1_ce  = ce_link[2];
    assign strobes_o.s2_ce  = ce_link[3];
    assign strobes_o.s3_ce  = ce_link[4];

    AST_S1_INSIDE_MOD: assert property (@(posedge clk) disable iff (rst)
        strobes_o.s1_ce |-> strobes_o.mod_ce); // R2

    AST_S3_INSIDE_S2: assert property (@(posedge clk) disable iff (rst)
        strobes_o.s3_ce |-> strobes_o.s2_ce); // R4

endmodule

// File: rtl/decim_settle_timer.sv
module decim_settle_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic [W-1:0] limit_i,
    output logic         settled_o
);

    logic [W-1:0] elapsed_q;
    logic         done_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            elapsed_q <= '0;
            done_q    <= 1'b0;
        end else if (!done_q) begin
            elapsed_q <= elapsed_q + W'(1);
            if (elapsed_q == limit_i - W'(1)) begin
                done_q <= 1'b1;
            end
        end
    end

    assign settled_o = done_q;

    AST_SETTLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> !settled_o); // R6

    AST_SETTLE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (settled_o && !clear_i) |=> settled_o); // R5

endmodule

// File: rtl/decim_timing_ctrl.sv
module decim_timing_ctrl
    import decim_timing_pkg::*;
#(
    parameter int SETTLE_64  = 7122,
    parameter int SETTLE_128 = 14217,
    parameter int SETTLE_256 = 27895
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_i,
    input  logic [1:0] rate_sel_i,
    output logic       mod_ce_o,
    output logic       s1_ce_o,
    output logic       s2_ce_o,
    output logic       odr_o,
    output logic       settled_o
);

    localparam int SETTLE_MAX_A = (SETTLE_64 > SETTLE_128) ? SETTLE_64 : SETTLE_128;
    localparam int SETTLE_MAX   = (SETTLE_MAX_A > SETTLE_256) ? SETTLE_MAX_A : SETTLE_256;
    localparam int SETTLE_W     = $clog2(SETTLE_MAX + 1);

    rate_e               rate_q;
    rate_e               rate_new;
    logic                restart;
    strobe_t             strobes;
    logic [SETTLE_W-1:0] settle_limit;
    logic                settled;

    assign rate_new = decode_rate(rate_sel_i);
    assign restart  = sync_i | (rate_new != rate_q);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            rate_q <= rate_new;
        end
    end

    always_comb begin
        case (rate_q)
            RATE_64:  settle_limit = SETTLE_W'(SETTLE_64);
            RATE_128: settle_limit = SETTLE_W'(SETTLE_128);
            default:  settle_limit = SETTLE_W'(SETTLE_256);
        endcase
    end

    decim_strobe_chain u_chain (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (restart),
        .rate_i    (rate_q),
        .strobes_o (strobes)
    );

    decim_settle_timer #(.W(SETTLE_W)) u_settle (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (restart),
        .limit_i   (settle_limit),
        .settled_o (settled)
    );

    assign mod_ce_o  = strobes.mod_ce;
    assign s1_ce_o   = strobes.s1_ce;
    assign s2_ce_o   = strobes.s2_ce;
    assign odr_o     = strobes.s3_ce & settled;
    assign settled_o = settled;

    AST_ODR_GATED: assert property (@(posedge clk) disable iff (rst)
        odr_o |-> settled_o); // R8

    AST_RESTART_ALIGN: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!mod_ce_o && !settled_o)); // R6

    AST_MOD_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
        mod_ce_o |=> !mod_ce_o); // R1

    AST_MOD_RESUME: assert property (@(posedge clk) disable iff (rst)
        (!mod_ce_o && !restart) |=> mod_ce_o); // R1

endmodule

// File: tb/decim_timing_ctrl_tb_top.sv
`timescale 1ns/100ps
module decim_timing_ctrl_tb_top;

    localparam int L64  = 300;
    localparam int L128 = 520;
    localparam int L256 = 900;

    typedef struct packed {
        logic mod_ce;
        logic s1;
        logic s2;
        logic odr;
        logic st;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_i = 1'b0;
    logic [1:0] rate_sel_i = 2'b00;
    logic       mod_ce_o, s1_ce_o, s2_ce_o, odr_o, settled_o;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    drv_done = 1'b0;
    bit    finished = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];

    int    m_n    = 0;
    int    m_rate = 0;

    always #2 clk = ~clk;

    decim_timing_ctrl #(
        .SETTLE_64  (L64),
        .SETTLE_128 (L128),
        .SETTLE_256 (L256)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .sync_i     (sync_i),
        .rate_sel_i (rate_sel_i),
        .mod_ce_o   (mod_ce_o),
        .s1_ce_o    (s1_ce_o),
        .s2_ce_o    (s2_ce_o),
        .odr_o      (odr_o),
        .settled_o  (settled_o)
    );

    // R9: 00 -> 64, 01 -> 128, 10 and 11 -> 256
    function automatic int code_of(input logic [1:0] r);
        return (r == 2'b00) ? 0 : (r == 2'b01) ? 1 : 2;
    endfunction

    function automatic exp_t expect_at(input int n, input int rc);
        exp_t e;
        int   d;
        int   lim;
        d   = 8 << rc;
        lim = (rc == 0) ? L64 : (rc == 1) ? L128 : L256;
        e.mod_ce = (n % 2) == 1;                      // R1
        e.s1     = (n % 8) == 7;                      // R2
        e.s2     = (n % (8 * d)) == (8 * d - 1);      // R3
        e.st     = n >= lim;                          // R5
        e.odr    = ((n % (16 * d)) == (16 * d - 1)) && e.st; // R4, R8
        return e;
    endfunction

    // Driver: applies inputs for one edge and pushes the expected outputs after it
    task automatic step(input bit s, input logic [1:0] r, input string tag);
        bit pend;
        sync_i     = s;
        rate_sel_i = r;
        pend = s || (code_of(r) != m_rate) || rst;
        @(posedge clk);
        if (pend) begin
            m_n    = 0;
            m_rate = code_of(r);
        end else begin
            m_n = m_n + 1;
        end
        exp_q.push_back(expect_at(m_n, m_rate));
        tag_q.push_back(tag);
        #1;
    endtask

    task automatic run(input int cycles, input logic [1:0] r, input string tag);
        for (int i = 0; i < cycles; i++) step(1'b0, r, tag);
    endtask

    task automatic field(input logic act, input logic exp, input string req, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s [%s] at %0t: actual=%b expected=%b", req, tag, $time, act, exp);
        end
    endtask

    // Monitor: pops one expected item per cycle and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                field(mod_ce_o,  e.mod_ce, "R1 mod_ce", t);
                field(s1_ce_o,   e.s1,     "R2 s1_ce", t);
                field(s2_ce_o,   e.s2,     "R3 s2_ce", t);
                field(odr_o,     e.odr,    "R4/R8 odr", t);
                field(settled_o, e.st,     "R5 settled", t);
            end
        end
    end

    initial begin
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b0, 2'b00, "R10 reset state");
        rst = 1'b0;
        run(1000, 2'b00, "R1 R2 R3 R4 R5 R8 rate 64");
        step(1'b1, 2'b00, "R6 sync when settled");
        run(450, 2'b00, "R6 after sync");
        step(1'b1, 2'b00, "R6 sync before settled");
        step(1'b1, 2'b00, "R6 sync held");
        run(400, 2'b00, "R6 after double sync");
        run(1300, 2'b01, "R7 switch to 128");
        run(1500, 2'b10, "R7 switch to 256");
        run(800, 2'b11, "R9 11 same as 10");
        run(600, 2'b10, "R9 back to 10");
        run(150, 2'b00, "R7 rate 64 cut short");
        run(1100, 2'b01, "R7 restart with 128 length");
        run(1200, 2'b11, "R9 11 from 128");
        rst = 1'b1;
        step(1'b0, 2'b01, "R10 reset mid run");
        rst = 1'b0;
        run(900, 2'b01, "R10 after second reset");
        drv_done = 1'b1;
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule